// File: doc/BRIEF.md
# Interrupt Redirection Table Unit

This unit watches 24 interrupt input lines and turns each active, enabled line into a message for the processor side. Each line owns a 64-bit routing entry. The entry holds the vector, the delivery mode, the destination mode, the destination, the polarity and trigger selection, and a mask. When a line fires, the unit marks the line's entry as waiting to deliver. It then offers the message on a valid/ready port. When several lines are waiting at once, the lowest-numbered line is offered first.

Level-triggered lines use a handshake with the interrupt receiver. After a level message is taken, the line is blocked until an end-of-interrupt carrying the same vector arrives on the EOI input. The line is then delivered again if it is still active. The delivery modes for system-management, non-maskable, init and external-controller interrupts always behave as edge-triggered. Software reaches the table through an index register and a 32-bit data window.

Top module: `irq_route_unit`

## Requirements
- R1: After reset every entry has its mask bit (bit 16) set and all other fields zero, and no message is offered. An even window at index 0 reads 0x00010000 and an odd window reads 0.
- R2: Index 2k selects bits [31:0] of entry k and index 2k+1 selects bits [63:32]. The low-half layout is: vector [7:0], delivery mode [10:8], destination mode [11], delivery-pending [12], polarity [13], remote-IRR [14], trigger [15], mask [16], and bits [31:17] read 0. The high half holds the destination in [31:24] and the rest reads 0. Writes leave bits 12 and 14 unchanged. An index of 48 or more reads 0, and writes to it are ignored.
- R3: An edge line (trigger bit 0) sends exactly one message for each change from inactive to active. Polarity 1 makes a low input the active level.
- R4: While an edge line's message is waiting, one more asserting edge is kept and sent after the first message. Further edges in that window are lost.
- R5: A masked line creates no message and keeps nothing pending, whether it is edge or level.
- R6: A level line sends a message when it is active and unmasked and both its pending and remote-IRR flags are clear. Acceptance sets remote-IRR. Only an EOI with an equal vector clears remote-IRR. The line then sends again if it is still active.
- R7: The delivery-pending bit reads 1 from the moment a message is generated until it is accepted.
- R8: Delivery modes 010, 100, 101 and 111 act as edge-triggered even with trigger bit 1. Their messages carry trig 0 and never set remote-IRR.
- R9: Messages in modes 010, 100 and 101 carry vector 0x00. All other modes carry the entry's vector.
- R10: With destination mode 0 the message destination is {4'h0, entry[59:56]}. With destination mode 1 it is entry[63:56].
- R11: When several lines are pending, the lowest-numbered line is offered first. While valid is high and ready is low, the offered line does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| irq_pins | input | 24 | Interrupt input lines |
| cfg_idx_we | input | 1 | Load window index from cfg_wdata[5:0] |
| cfg_win_we | input | 1 | Write cfg_wdata to the selected entry half |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Contents of the selected entry half |
| msg_valid | output | 1 | A message is offered |
| msg_ready | input | 1 | The receiver accepts the offered message |
| msg_pin | output | 5 | Source line of the message |
| msg_vector | output | 8 | Message vector |
| msg_dmode | output | 3 | Delivery mode |
| msg_destmode | output | 1 | Destination mode (0 physical, 1 logical) |
| msg_dest | output | 8 | Destination |
| msg_trig | output | 1 | 1 when delivered with level semantics |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_vector | input | 8 | Vector of the end-of-interrupt |

## Verification
The bench targets the edge-storage window. It sends three edges while the port is stalled and expects exactly two messages; a design without the spare slot would lose the second edge, and one without a bound would send three. It checks that a level line stays quiet after acceptance, ignores an EOI with a foreign vector, and fires again only on the matching EOI if the line is still high. A design that skipped the remote-IRR block would flood the port. Forced-edge modes are driven with the trigger bit set and the line held high, so a design that honoured the trigger bit would wait for an EOI that never arrives or would repeat the message. Simultaneous and staggered pending lines test both the lowest-first order and the hold-while-stalled rule; a design that re-arbitrated under stall would swap the offered line.

// File: rtl/irq_route_pkg.sv
`timescale 1ns/1ps
package irq_route_pkg;

  localparam logic [2:0] DM_FIXED  = 3'b000;
  localparam logic [2:0] DM_LOWPRI = 3'b001;
  localparam logic [2:0] DM_SMI    = 3'b010;
  localparam logic [2:0] DM_NMI    = 3'b100;
  localparam logic [2:0] DM_INIT   = 3'b101;

  typedef struct packed {
    logic [7:0] dest;
    logic       destmode;
    logic [2:0] dmode;
    logic [7:0] vector;
    logic       trig;
  } irq_msg_t;

  // level handling applies only to the two ordinary interrupt modes
  function automatic logic level_semantics(input logic trig_bit, input logic [2:0] dm);
    return trig_bit && (dm == DM_FIXED || dm == DM_LOWPRI);
  endfunction

  function automatic logic vector_carried(input logic [2:0] dm);
    return !(dm == DM_SMI || dm == DM_NMI || dm == DM_INIT);
  endfunction

  function automatic logic [7:0] route_dest(input logic dmode_logical, input logic [7:0] raw);
    return dmode_logical ? raw : {4'h0, raw[3:0]};
  endfunction

  function automatic irq_msg_t build_msg(input logic [7:0] dest, input logic destmode,
                                         input logic [2:0] dm, input logic [7:0] vec,
                                         input logic trig_bit);
    irq_msg_t m;
    m.dest     = route_dest(destmode, dest);
    m.destmode = destmode;
    m.dmode    = dm;
    m.vector   = vector_carried(dm) ? vec : 8'h00;
    m.trig     = level_semantics(trig_bit, dm);
    return m;
  endfunction

endpackage

// File: rtl/irq_pin_ctrl.sv
`timescale 1ns/1ps
module irq_pin_ctrl
  import irq_route_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        pin_in,
  input  logic        wr_lo,
  input  logic        wr_hi,
  input  logic [31:0] wdata,
  input  logic        eoi_valid,
  input  logic [7:0]  eoi_vector,
  input  logic        grant,
  output logic        pend,
  output logic [31:0] rd_lo,
  output logic [31:0] rd_hi,
  output irq_msg_t    msg_out
);

  logic [7:0] dest_q;
  logic       mask_q, trig_q, pol_q, destmod_q;
  logic [2:0] dmode_q;
  logic [7:0] vec_q;
  logic       act_q, prev_q, pend_q, held_q, rirr_q;

  // named internal events
  logic level_mode, edge_evt, level_req, eoi_hit;
  assign level_mode = level_semantics(trig_q, dmode_q);
  assign edge_evt   = !level_mode && !mask_q && act_q && !prev_q;
  assign level_req  = level_mode && !mask_q && act_q && !rirr_q && !pend_q;
  assign eoi_hit    = eoi_valid && (eoi_vector == vec_q);

  logic unused_wbits;
  assign unused_wbits = ^{wdata[23:17], wdata[14], wdata[12]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dest_q <= '0; mask_q <= 1'b1; trig_q <= 1'b0; pol_q <= 1'b0;
      destmod_q <= 1'b0; dmode_q <= '0; vec_q <= '0;
      act_q <= 1'b0; prev_q <= 1'b0;
      pend_q <= 1'b0; held_q <= 1'b0; rirr_q <= 1'b0;
    end else begin
      act_q  <= pin_in ^ pol_q;
      prev_q <= act_q;
      if (wr_lo) begin
        vec_q     <= wdata[7:0];
        dmode_q   <= wdata[10:8];
        destmod_q <= wdata[11];
        pol_q     <= wdata[13];
        trig_q    <= wdata[15];
        mask_q    <= wdata[16];
      end
      if (wr_hi) dest_q <= wdata[31:24];
      if (grant) begin
        pend_q <= held_q | edge_evt;
        held_q <= held_q & edge_evt;
      end else if (edge_evt) begin
        pend_q <= 1'b1;
        held_q <= held_q | pend_q;
      end else if (level_req) begin
        pend_q <= 1'b1;
      end
      if (grant && level_mode) rirr_q <= 1'b1;
      else if (eoi_hit)        rirr_q <= 1'b0;
    end
  end

  assign pend    = pend_q;
  assign rd_lo   = {15'b0, mask_q, trig_q, rirr_q, pol_q, pend_q, destmod_q, dmode_q, vec_q};
  assign rd_hi   = {dest_q, 24'b0};
  assign msg_out = build_msg(dest_q, destmod_q, dmode_q, vec_q, trig_q);

  AST_MASK_NO_NEW_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    mask_q && !pend_q |=> !pend_q); // R5
  AST_RIRR_BLOCKS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    rirr_q && !pend_q && level_mode && !eoi_hit |=> !pend_q); // R6
  AST_ACCEPT_SETS_RIRR: assert property (@(posedge clk) disable iff (!rst_n)
    grant && level_mode |=> rirr_q); // R6
  AST_GRANT_CLEARS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    grant && !held_q && !edge_evt |=> !pend_q); // R7
  AST_GRANT_ONLY_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> pend_q); // R11

endmodule

// File: rtl/irq_arbiter.sv
`timescale 1ns/1ps
module irq_arbiter #(
  parameter int N     = 24,
  parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     req,
  input  logic             ready,
  output logic             valid,
  output logic [IDX_W-1:0] idx,
  output logic [N-1:0]     grant
);

  function automatic logic [IDX_W-1:0] lowest_set(input logic [N-1:0] r);
    logic [IDX_W-1:0] k;
    k = '0;
    for (int i = N - 1; i >= 0; i--) if (r[i]) k = IDX_W'(i);
    return k;
  endfunction

  logic             lock_q;
  logic [IDX_W-1:0] lock_idx_q;
  logic             accept;

  assign valid  = |req;
  assign idx    = lock_q ? lock_idx_q : lowest_set(req);
  assign accept = valid && ready;

  always_comb begin
    grant = '0;
    if (accept) grant[idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= 1'b0;
      lock_idx_q <= '0;
    end else begin
      lock_q     <= valid && !ready;
      lock_idx_q <= idx;
    end
  end

  AST_HOLD_WHILE_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    valid && !ready |=> valid && $stable(idx)); // R11
  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant)); // R11

endmodule

// File: rtl/irq_route_unit.sv
`timescale 1ns/1ps
module irq_route_unit
  import irq_route_pkg::*;
#(
  parameter int NUM_PINS = 24,
  parameter int PIN_W    = $clog2(NUM_PINS),
  parameter int IDX_W    = $clog2(2 * NUM_PINS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] irq_pins,
  input  logic                cfg_idx_we,
  input  logic                cfg_win_we,
  input  logic [31:0]         cfg_wdata,
  output logic [31:0]         cfg_rdata,
  output logic                msg_valid,
  input  logic                msg_ready,
  output logic [PIN_W-1:0]    msg_pin,
  output logic [7:0]          msg_vector,
  output logic [2:0]          msg_dmode,
  output logic                msg_destmode,
  output logic [7:0]          msg_dest,
  output logic                msg_trig,
  input  logic                eoi_valid,
  input  logic [7:0]          eoi_vector
);

  logic [IDX_W-1:0] idx_q;
  logic             half_hi, sel_ok;
  logic [IDX_W-2:0] pin_sel;

  assign half_hi = idx_q[0];
  assign pin_sel = idx_q[IDX_W-1:1];
  assign sel_ok  = int'(pin_sel) < NUM_PINS;

  logic unused_idx;
  assign unused_idx = ^cfg_wdata[31:IDX_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          idx_q <= '0;
    else if (cfg_idx_we) idx_q <= cfg_wdata[IDX_W-1:0];
  end

  logic [NUM_PINS-1:0] pend_vec, grant_vec;
  logic [31:0]         rd_lo [NUM_PINS];
  logic [31:0]         rd_hi [NUM_PINS];
  irq_msg_t            msg_arr [NUM_PINS];

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    logic sel_here;
    assign sel_here = cfg_win_we && sel_ok && (int'(pin_sel) == g);
    irq_pin_ctrl u_pin (
      .clk        (clk),
      .rst_n      (rst_n),
      .pin_in     (irq_pins[g]),
      .wr_lo      (sel_here && !half_hi),
      .wr_hi      (sel_here && half_hi),
      .wdata      (cfg_wdata),
      .eoi_valid  (eoi_valid),
      .eoi_vector (eoi_vector),
      .grant      (grant_vec[g]),
      .pend       (pend_vec[g]),
      .rd_lo      (rd_lo[g]),
      .rd_hi      (rd_hi[g]),
      .msg_out    (msg_arr[g])
    );
  end

  always_comb begin
    cfg_rdata = '0;
    for (int i = 0; i < NUM_PINS; i++)
      if (sel_ok && int'(pin_sel) == i) cfg_rdata = half_hi ? rd_hi[i] : rd_lo[i];
  end

  irq_arbiter #(.N(NUM_PINS), .IDX_W(PIN_W)) u_arb (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (pend_vec),
    .ready (msg_ready),
    .valid (msg_valid),
    .idx   (msg_pin),
    .grant (grant_vec)
  );

  irq_msg_t cur_msg;
  always_comb begin
    cur_msg = '0;
    for (int i = 0; i < NUM_PINS; i++)
      if (int'(msg_pin) == i) cur_msg = msg_arr[i];
  end

  assign msg_vector   = cur_msg.vector;
  assign msg_dmode    = cur_msg.dmode;
  assign msg_destmode = cur_msg.destmode;
  assign msg_dest     = cur_msg.dest;
  assign msg_trig     = cur_msg.trig;

  AST_VALID_MATCHES_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> pend_vec[msg_pin]); // R7
  AST_PHYS_DEST_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && !msg_destmode |-> msg_dest[7:4] == 4'h0); // R10

endmodule

// File: tb/irq_route_unit_tb_top.sv
`timescale 1ns/1ps
module irq_route_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] pins = '0;
  logic        cfg_idx_we = 1'b0, cfg_win_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        msg_valid, msg_ready = 1'b1;
  logic [4:0]  msg_pin;
  logic [7:0]  msg_vector, msg_dest;
  logic [2:0]  msg_dmode;
  logic        msg_destmode, msg_trig;
  logic        eoi_valid = 1'b0;
  logic [7:0]  eoi_vector = '0;

  int checks = 0, errors = 0;
  logic [25:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk; // 50 MHz

  irq_route_unit dut_i (
    .clk(clk), .rst_n(rst_n), .irq_pins(pins),
    .cfg_idx_we(cfg_idx_we), .cfg_win_we(cfg_win_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .msg_valid(msg_valid), .msg_ready(msg_ready),
    .msg_pin(msg_pin), .msg_vector(msg_vector), .msg_dmode(msg_dmode),
    .msg_destmode(msg_destmode), .msg_dest(msg_dest), .msg_trig(msg_trig),
    .eoi_valid(eoi_valid), .eoi_vector(eoi_vector)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic set_idx(input int i);
    cfg_wdata = 32'(i); cfg_idx_we = 1'b1; cyc(1); cfg_idx_we = 1'b0;
  endtask

  task automatic wr(input int i, input logic [31:0] d);
    set_idx(i); cfg_wdata = d; cfg_win_we = 1'b1; cyc(1); cfg_win_we = 1'b0;
  endtask

  task automatic rd(input int i, output logic [31:0] d);
    set_idx(i); @(negedge clk); d = cfg_rdata; cyc(1);
  endtask

  // expected message model, written from the requirements
  task automatic expect_msg(input int pin, input logic [7:0] vec, input logic [2:0] dm,
                            input logic dmd, input logic [7:0] raw_dest,
                            input logic trig_bit, input string tag);
    logic [7:0] v, d;
    logic       t;
    v = (dm == 3'b010 || dm == 3'b100 || dm == 3'b101) ? 8'h00 : vec;
    d = dmd ? raw_dest : {4'h0, raw_dest[3:0]};
    t = trig_bit && (dm == 3'b000 || dm == 3'b001);
    exp_q.push_back({5'(pin), v, dm, dmd, d, t});
    tag_q.push_back(tag);
  endtask

  task automatic idle_check(input string tag);
    cyc(12);
    check({tag, " queue drained"}, 32'(exp_q.size()), 0);
    @(negedge clk);
    check({tag, " no extra message"}, {31'b0, msg_valid}, 0);
    cyc(1);
  endtask

  task automatic pulse(input int p);
    pins[p] = 1'b1; cyc(3); pins[p] = 1'b0; cyc(3);
  endtask

  task automatic eoi(input logic [7:0] v);
    eoi_vector = v; eoi_valid = 1'b1; cyc(1); eoi_valid = 1'b0;
  endtask

  // monitor: pops the scoreboard on every accepted message
  always @(negedge clk) begin
    if (rst_n && msg_valid && msg_ready) begin
      logic [25:0] act;
      act = {msg_pin, msg_vector, msg_dmode, msg_destmode, msg_dest, msg_trig};
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R11 unexpected message actual=%h expected=none", act);
      end else begin
        logic [25:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (act !== e) begin
          errors++;
          $display("FAIL %s message actual=%h expected=%h", t, act, e);
        end
      end
    end
  end

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    pins[4] = 1'b1;
    cyc(3); rst_n = 1'b1; cyc(2);

    // R1 reset state
    @(negedge clk);
    check("R1 reset no valid", {31'b0, msg_valid}, 0);
    check("R1 entry0 low", cfg_rdata, 32'h0001_0000);
    cyc(1);
    rd(1, d);  check("R1 entry0 high", d, 0);
    rd(46, d); check("R1 entry23 low", d, 32'h0001_0000);

    // R2 window layout, read-only bits, out-of-range index
    wr(6, 32'h0000_5031);
    rd(6, d); check("R2 ro bits kept", d, 32'h0000_0031);
    wr(7, 32'h25AB_CDEF);
    rd(7, d); check("R2 high half", d, 32'h2500_0000);
    wr(50, 32'hFFFF_FFFF);
    rd(50, d); check("R2 index beyond table", d, 0);

    // R3 / R10 physical: pin 3 edge
    expect_msg(3, 8'h31, 3'b000, 1'b0, 8'h25, 1'b0, "R3 R10 physical");
    pulse(3);
    idle_check("R3");

    // R3 polarity + R10 logical: pin 4 active low
    wr(9, 32'hA500_0000);
    wr(8, 32'h0000_2841);
    cyc(3);
    rd(8, d); check("R2 pin4 low half", d, 32'h0000_2841);
    expect_msg(4, 8'h41, 3'b000, 1'b1, 8'hA5, 1'b0, "R3 R10 active low logical");
    pins[4] = 1'b0; cyc(3); pins[4] = 1'b1;
    idle_check("R3 polarity");

    // R5 masked edge pin 5
    pulse(5);
    idle_check("R5 masked edge");
    rd(10, d); check("R5 nothing pending", d, 32'h0001_0000);

    // R4 / R7 edge storage under stall
    wr(12, 32'h0000_0066);
    msg_ready = 1'b0;
    pulse(6); pulse(6); pulse(6);
    rd(12, d); check("R7 pending bit", d, 32'h0000_1066);
    @(negedge clk);
    check("R7 valid while stalled", {31'b0, msg_valid}, 1);
    check("R7 pin offered", {27'b0, msg_pin}, 6);
    cyc(1);
    expect_msg(6, 8'h66, 3'b000, 1'b0, 8'h00, 1'b0, "R4 first");
    expect_msg(6, 8'h66, 3'b000, 1'b0, 8'h00, 1'b0, "R4 held edge");
    msg_ready = 1'b1;
    idle_check("R4 third edge lost");
    rd(12, d); check("R7 pending cleared", d, 32'h0000_0066);

    // R11 simultaneous pins: lowest first
    wr(14, 32'h0000_0077);
    wr(18, 32'h0000_0099);
    msg_ready = 1'b0;
    pins[7] = 1'b1; pins[9] = 1'b1; cyc(3); pins[7] = 1'b0; pins[9] = 1'b0; cyc(3);
    expect_msg(7, 8'h77, 3'b000, 1'b0, 8'h00, 1'b0, "R11 lowest first");
    expect_msg(9, 8'h99, 3'b000, 1'b0, 8'h00, 1'b0, "R11 second");
    msg_ready = 1'b1;
    idle_check("R11 simultaneous");

    // R11 hold while stalled: pin 9 offered before pin 7 arrives
    msg_ready = 1'b0;
    pulse(9); pulse(7);
    @(negedge clk);
    check("R11 offered line held", {27'b0, msg_pin}, 9);
    cyc(1);
    expect_msg(9, 8'h99, 3'b000, 1'b0, 8'h00, 1'b0, "R11 held first");
    expect_msg(7, 8'h77, 3'b000, 1'b0, 8'h00, 1'b0, "R11 later lower");
    msg_ready = 1'b1;
    idle_check("R11 stall order");

    // R6 level pin 10
    wr(20, 32'h0000_80A0);
    expect_msg(10, 8'hA0, 3'b000, 1'b0, 8'h00, 1'b1, "R6 level first");
    pins[10] = 1'b1;
    idle_check("R6 blocked by remote IRR");
    rd(20, d); check("R6 remote IRR set", d, 32'h0000_C0A0);
    eoi(8'h55);
    idle_check("R6 foreign EOI");
    expect_msg(10, 8'hA0, 3'b000, 1'b0, 8'h00, 1'b1, "R6 redeliver after EOI");
    eoi(8'hA0);
    idle_check("R6 matching EOI");
    pins[10] = 1'b0; cyc(3);
    eoi(8'hA0);
    idle_check("R6 inactive after EOI");
    rd(20, d); check("R6 remote IRR cleared", d, 32'h0000_80A0);

    // R8 / R9 NMI with trigger bit set
    wr(22, 32'h0000_843C);
    expect_msg(11, 8'h3C, 3'b100, 1'b0, 8'h00, 1'b1, "R8 R9 NMI");
    pins[11] = 1'b1;
    idle_check("R8 held high single");
    rd(22, d); check("R8 no remote IRR", d, 32'h0000_843C);
    pins[11] = 1'b0; cyc(3);
    expect_msg(11, 8'h3C, 3'b100, 1'b0, 8'h00, 1'b1, "R8 second edge");
    pins[11] = 1'b1; cyc(3); pins[11] = 1'b0;
    idle_check("R8 NMI again");

    // R9 ExtINT keeps its vector, R8 edge semantics
    wr(25, 32'hFF00_0000);
    wr(24, 32'h0000_8F7E);
    expect_msg(12, 8'h7E, 3'b111, 1'b1, 8'hFF, 1'b1, "R9 R8 external mode");
    pins[12] = 1'b1;
    idle_check("R9 external");
    pins[12] = 1'b0; cyc(2);

    // R5 masked level pin 13, then unmask
    wr(26, 32'h0001_8013);
    pins[13] = 1'b1;
    idle_check("R5 masked level");
    expect_msg(13, 8'h13, 3'b000, 1'b0, 8'h00, 1'b1, "R5 unmasked level");
    wr(26, 32'h0000_8013);
    idle_check("R5 after unmask");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule